// File: doc/BRIEF.md
# Banked Memory Paging Port

This block is the write-only control register that pages RAM for a home-computer memory system built from eight 16 KB RAM banks. It watches I/O writes from a Z80-style bus and keeps the control byte from any write whose address it recognises. From that byte it drives the bank number mapped into the 0xC000–0xFFFF window, and it tells the video fetch logic which of two fixed banks holds the displayed picture. It also reports the byte range of the 6912-byte screen area.

A lock bit in the control byte stops all further writes until the next reset. This freezes the memory map once system software has set it. The top window is flagged as contended whenever the bank mapped there is one that the video side shares. A one-cycle strobe goes out each time an accepted write changes the screen bank, so the video side can flush pending output before it switches banks.

Top module: `paging_port`

## Requirements
- R1: A write is accepted when `io_wr` is high, address bit 15 is 0, address bit 1 is 0 and address bit 0 is 1. All other address bits are ignored.
- R2: A write that fails the decode in R1, or any cycle with `io_wr` low, leaves every output as it was.
- R3: `top_bank` equals bits 2:0 of the last accepted control byte.
- R4: `screen_bank` is 7 when bit 3 of the last accepted byte is 1, and 5 when it is 0.
- R5: `screen_base` equals `screen_bank` × 16384, and `screen_last` equals `screen_base` + 6911.
- R6: `top_contended` is 1 exactly when bits 0 and 2 of the last accepted byte are both 1.
- R7: An accepted byte with bit 5 set takes effect. After it, every write is ignored until reset.
- R8: `screen_swap` is high for one cycle, in the cycle after an accepted write whose bit 3 differs from the stored bit 3. It is low otherwise, including after blocked writes.
- R9: With `rst_n` low, the register is cleared: `top_bank` 0, `screen_bank` 5, `top_contended` 0, `screen_swap` 0, and the lock is released.
- R10: An accepted write shows on the outputs in the cycle following the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O address |
| io_data | input | 8 | I/O write data |
| top_bank | output | 3 | RAM bank mapped at 0xC000–0xFFFF |
| screen_bank | output | 3 | Bank holding the displayed screen |
| screen_base | output | 17 | First byte of the screen area in RAM |
| screen_last | output | 17 | Last byte of the screen area in RAM |
| top_contended | output | 1 | Top window holds a contended bank |
| screen_swap | output | 1 | One-cycle strobe when the screen bank changes |

## Verification
A wrong stored byte shows on `top_bank`, `screen_bank` or `top_contended` in the very next cycle, because these outputs are decoded straight from the register with no pipeline. A lock flag that is set wrongly, or a decode that is too loose or too strict, shows only when a later write is applied. The bench therefore sweeps every address with a write behind it, and tries to overwrite each data value after it is stored. A wrong strobe is visible for a single cycle only, so the strobe is compared on every vector.

// File: rtl/paging_pkg.sv
package paging_pkg;
    localparam int BANK_W      = 3;
    localparam int BANK_LOG2   = 14;
    localparam int SPAN_W      = BANK_W + BANK_LOG2;
    localparam int DATA_W      = 8;
    localparam int SCREEN_LEN  = 6912;
    localparam int SCREEN_LO   = 5;
    localparam int SCREEN_HI   = 7;
    localparam int SEL_BIT     = 3;
    localparam int LOCK_BIT    = 5;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              sel;
        logic              lock;
        logic              swap;
    } pg_state_t;
endpackage

// File: rtl/pg_decode.sv
module pg_decode #(
    parameter int ADDR_W = 16
) (
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              hit
);
    // Partial decode: top bit low, bit 1 low, bit 0 high (bit 0 low is the border port)
    always_comb begin
        hit = io_wr && !io_addr[ADDR_W-1] && !io_addr[1] && io_addr[0];
    end
endmodule

// File: rtl/pg_reg.sv
module pg_reg
    import paging_pkg::*;
#(
    parameter int BW      = BANK_W,
    parameter int DW      = DATA_W,
    parameter int SEL_POS = SEL_BIT,
    parameter int LCK_POS = LOCK_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [DW-1:0] data,
    output logic [BW-1:0] bank_q,
    output logic          sel_q,
    output logic          lock_q,
    output logic          swap_q
);
    typedef struct packed {
        logic [BW-1:0] bank;
        logic          sel;
        logic          lock;
        logic          swap;
    } st_t;

    st_t state_d, state_q;
    logic take_d;

    always_comb begin
        state_d      = state_q;
        take_d       = hit && !state_q.lock;
        state_d.swap = 1'b0;
        if (take_d) begin
            state_d.bank = data[BW-1:0];
            state_d.sel  = data[SEL_POS];
            state_d.lock = data[LCK_POS];
            state_d.swap = data[SEL_POS] ^ state_q.sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bank_q = state_q.bank;
    assign sel_q  = state_q.sel;
    assign lock_q = state_q.lock;
    assign swap_q = state_q.swap;
endmodule

// File: rtl/pg_map.sv
module pg_map
    import paging_pkg::*;
#(
    parameter int BW     = BANK_W,
    parameter int BLOG   = BANK_LOG2,
    parameter int LEN    = SCREEN_LEN,
    parameter int LO     = SCREEN_LO,
    parameter int HI     = SCREEN_HI
) (
    input  logic [BW-1:0]      bank,
    input  logic               sel,
    output logic [BW-1:0]      scr_bank,
    output logic [BW+BLOG-1:0] scr_base,
    output logic [BW+BLOG-1:0] scr_last,
    output logic               contended
);
    localparam int AW = BW + BLOG;
    localparam logic [BW-1:0] LO_V = BW'(LO);
    localparam logic [BW-1:0] HI_V = BW'(HI);
    localparam logic [AW-1:0] LEN_M1 = AW'(LEN - 1);

    always_comb begin
        scr_bank  = sel ? HI_V : LO_V;
        scr_base  = {scr_bank, {BLOG{1'b0}}};
        scr_last  = scr_base + LEN_M1;
        // Banks shared with video: low bit and bit 2 both set
        contended = bank[0] && bank[2];
    end
endmodule

// File: rtl/paging_port.sv
module paging_port
    import paging_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_wr,
    input  logic [15:0] io_addr,
    input  logic [7:0]  io_data,
    output logic [2:0]  top_bank,
    output logic [2:0]  screen_bank,
    output logic [16:0] screen_base,
    output logic [16:0] screen_last,
    output logic        top_contended,
    output logic        screen_swap
);
    logic             hit;
    logic [BANK_W-1:0] bank_q;
    logic             sel_q;
    logic             lock_q;
    logic             swap_q;

    pg_decode #(.ADDR_W(16)) u_dec (
        .io_wr  (io_wr),
        .io_addr(io_addr),
        .hit    (hit)
    );

    pg_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .data  (io_data),
        .bank_q(bank_q),
        .sel_q (sel_q),
        .lock_q(lock_q),
        .swap_q(swap_q)
    );

    pg_map u_map (
        .bank     (bank_q),
        .sel      (sel_q),
        .scr_bank (screen_bank),
        .scr_base (screen_base),
        .scr_last (screen_last),
        .contended(top_contended)
    );

    assign top_bank    = bank_q;
    assign screen_swap = swap_q;
endmodule

// File: rtl/paging_port_chk.sv
module paging_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hit,
    input logic        lock_q,
    input logic [2:0]  top_bank,
    input logic [2:0]  screen_bank,
    input logic [16:0] screen_base,
    input logic [16:0] screen_last,
    input logic        top_contended,
    input logic        screen_swap
);
    assert_locked_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(top_bank) && $stable(screen_bank) && lock_q));

    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(top_bank) && $stable(screen_bank) && !screen_swap));

    assert_swap_changes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        screen_swap |-> (screen_bank != $past(screen_bank)));

    assert_screen_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (screen_bank == 3'd5) || (screen_bank == 3'd7));

    assert_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (screen_last - screen_base) == 17'd6911);

    assert_contended_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        top_contended |-> (top_bank == 3'd5 || top_bank == 3'd7));
endmodule

bind paging_port paging_port_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit          (hit),
    .lock_q       (lock_q),
    .top_bank     (top_bank),
    .screen_bank  (screen_bank),
    .screen_base  (screen_base),
    .screen_last  (screen_last),
    .top_contended(top_contended),
    .screen_swap  (screen_swap)
);

// File: tb/tb_paging_port.sv
module tb_paging_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_data = '0;
    logic [2:0]  top_bank, screen_bank;
    logic [16:0] screen_base, screen_last;
    logic        top_contended, screen_swap;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic [7:0] m_reg;
    logic       m_swap;

    always #2.5 clk = ~clk;

    paging_port dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
        .top_bank(top_bank), .screen_bank(screen_bank), .screen_base(screen_base),
        .screen_last(screen_last), .top_contended(top_contended), .screen_swap(screen_swap)
    );

    task automatic check(input string tag);
        logic [2:0]  e_scr;
        logic [16:0] e_base;
        bit bad;
        e_scr  = m_reg[3] ? 3'd7 : 3'd5;
        e_base = 17'(e_scr) * 17'd16384;
        bad = 1'b0;
        vectors++;
        if (top_bank !== m_reg[2:0]) begin
            $display("FAIL R3 %s top_bank got %0d exp %0d", tag, top_bank, m_reg[2:0]); bad = 1'b1;
        end
        if (screen_bank !== e_scr) begin
            $display("FAIL R4 %s screen_bank got %0d exp %0d", tag, screen_bank, e_scr); bad = 1'b1;
        end
        if (screen_base !== e_base || screen_last !== e_base + 17'd6911) begin
            $display("FAIL R5 %s base/last got %0d/%0d exp %0d/%0d", tag, screen_base,
                     screen_last, e_base, e_base + 17'd6911); bad = 1'b1;
        end
        if (top_contended !== (m_reg[0] & m_reg[2])) begin
            $display("FAIL R6 %s contended got %0b exp %0b", tag, top_contended, m_reg[0] & m_reg[2]);
            bad = 1'b1;
        end
        if (screen_swap !== m_swap) begin
            $display("FAIL R8 %s swap got %0b exp %0b", tag, screen_swap, m_swap); bad = 1'b1;
        end
        if (bad) misses++;
    endtask

    // Drive at negedge, capture at posedge, check at next negedge (R10)
    task automatic step(input logic [15:0] a, input logic [7:0] d, input logic w, input string tag);
        bit take;
        io_addr = a; io_data = d; io_wr = w;
        @(posedge clk);
        take   = w && !a[15] && !a[1] && a[0] && !m_reg[5];
        m_swap = take && (d[3] != m_reg[3]);
        if (take) m_reg = d;
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset();
        io_wr = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        m_reg = 8'h00; m_swap = 1'b0;
        check("R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset");
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        m_reg = 8'h00; m_swap = 1'b0;
        @(negedge clk);
        do_reset();

        // R1/R2: every address, with unlocking data that varies with address
        for (int a = 0; a < 65536; a++) begin
            step(16'(a), 8'(a) & 8'hDF, 1'b1, "R1 R2 addr sweep");
        end

        // R2: io_wr low at a decoding address
        for (int d = 0; d < 256; d++) begin
            step(16'h7FFD, 8'(d), 1'b0, "R2 no strobe");
        end

        // R7, R8, R9: each data value, then attempted overwrite
        for (int d = 0; d < 256; d++) begin
            do_reset();
            step(16'h7FFD, 8'(d), 1'b1, "R7 R8 first write");
            step(16'h7FFD, ~8'(d), 1'b1, "R7 overwrite");
            step(16'h7FFD, 8'(d) ^ 8'h08, 1'b1, "R7 R8 flip sel");
            step(16'h7FFD, 8'(d) ^ 8'h08, 1'b1, "R8 same sel twice");
        end

        // R7: after locking, sweep address space with writes
        do_reset();
        step(16'h0001, 8'h2D, 1'b1, "R7 lock");
        for (int a = 0; a < 4096; a++) begin
            step(16'(a * 16 + 1), 8'(a), 1'b1, "R7 locked sweep");
        end
        do_reset();
        step(16'h3FF5, 8'h0F, 1'b1, "R9 unlocked after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule